// File: doc/BRIEF.md
# External Event Edge Counter

This block counts transitions on an external event pin that is asynchronous to the system clock. The pin is brought into the clock domain through a two-flop synchronizer. A filter can be switched in that accepts a new pin level only after that level has held steady for several clocks. The block watches the resulting level for transitions in the direction that software selects. Each qualifying transition produces one single-cycle pulse. That pulse advances a free-running counter whose value software reads.

Edge direction, filter enable and counter enable are plain level inputs. When the edge direction or the filter setting changes, the block discards its edge history so that the change itself is never taken as an event. Without the filter, the pin may change at up to one third of the clock rate. With the filter, the limit is one eighth of the clock rate.

Top module: `event_edge_counter`

## Requirements
- R1: While `rst` is high and in the first cycle after it falls, `count` is 0 and `evt_pulse` is 0.
- R2: With `deb_en`=0, a pin level first sampled at clock edge k raises `evt_pulse` after edge k+2. `count` shows the increment after edge k+3.
- R3: With `edge_rise`=1 only 0-to-1 transitions of the pin are counted. With `edge_rise`=0 only 1-to-0 transitions are counted.
- R4: With `deb_en`=1 the filtered level takes a new value only after the synchronized pin has held that value for 3 consecutive clocks. Pin excursions of 1 or 2 clocks produce no pulse and no count.
- R5: With `deb_en`=1, a qualifying pin change first sampled at edge k raises `evt_pulse` after edge k+5.
- R6: Every qualifying transition gives exactly one pulse, one clock wide. `evt_pulse` is never high on two consecutive cycles.
- R7: Each pulse adds exactly one to `count` when `cnt_en` is 1 in the pulse cycle. With `cnt_en`=0 the pulse still appears and `count` holds.
- R8: `count` wraps from 2^CNT_W-1 to 0.
- R9: A change of `edge_rise` or `deb_en` reseeds the edge history. No pulse follows in the next cycle, and a level step caused only by the filter switch is not counted.
- R10: Any sequence of pin levels counts exactly as the requirements above predict. Without the filter, every level run of one clock or more is seen. With the filter, runs of at least 3 clocks are seen.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, also the sampling clock |
| rst | input | 1 | Synchronous active-high reset |
| evt_pin | input | 1 | Raw asynchronous event pin |
| edge_rise | input | 1 | 1: count rising transitions, 0: count falling transitions |
| deb_en | input | 1 | 1: pass the pin through the 3-clock filter |
| cnt_en | input | 1 | 1: pulses advance the counter |
| count | output | CNT_W | Event count, registered |
| evt_pulse | output | 1 | One-cycle pulse per qualifying transition, registered |

## Verification
The hardest case to reach is the filter being switched while the synchronized pin and the filtered level disagree. A false level step arises only then. The directed stimulus creates this disagreement on purpose: it drives a two-clock pin excursion and toggles `deb_en` on the exact clock in which the filter is still holding the old level. The bench then shows that no pulse and no count follow. The random phases check the filter threshold. Each phase mixes excursions of 1 and 2 clocks with runs of 3 clocks or more, under all four combinations of edge direction and filter setting. A second copy of the block with a 4-bit counter is used to check wrap-around.

// File: rtl/evc_pkg.sv
package evc_pkg;

  typedef struct packed {
    logic rise;
    logic deb;
  } evc_cfg_t;

  function automatic logic edge_hit(input logic rise, input logic prev, input logic cur);
    return rise ? (cur & ~prev) : (~cur & prev);
  endfunction

endpackage

// File: rtl/evt_sync.sv
module evt_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] sh;

  always_ff @(posedge clk) begin
    if (rst) sh <= '0;
    else     sh <= {sh[STAGES-2:0], d};
  end

  assign q = sh[STAGES-1];
endmodule

// File: rtl/evt_debounce.sv
module evt_debounce #(
  parameter int HOLD = 3
) (
  input  logic clk,
  input  logic rst,
  input  logic din,
  output logic dout
);
  localparam int CW = $clog2(HOLD + 1);

  logic          filt_q;
  logic [CW-1:0] hcnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      filt_q <= 1'b0;
      hcnt   <= '0;
    end else if (din == filt_q) begin
      hcnt <= '0;
    end else if (hcnt == CW'(HOLD - 1)) begin
      filt_q <= din;
      hcnt   <= '0;
    end else begin
      hcnt <= hcnt + 1'b1;
    end
  end

  assign dout = filt_q;

  // Checker: counts consecutive repeats of din, separate from the filter counter.
  logic          din_d;
  logic [CW-1:0] run_len;
  always_ff @(posedge clk) begin
    if (rst) begin
      din_d   <= 1'b0;
      run_len <= '0;
    end else begin
      din_d   <= din;
      if (din != din_d)               run_len <= '0;
      else if (run_len != CW'(HOLD))  run_len <= run_len + 1'b1;
    end
  end

  // R4: the filtered level moves only after din held the new value long enough.
  assert_filter_hold_R4: assert property (@(posedge clk) disable iff (rst)
    !$stable(filt_q) |-> ($past(din) == filt_q && $past(din, 2) == filt_q &&
                          $past(run_len) >= CW'(HOLD - 2)));
endmodule

// File: rtl/evt_edge_det.sv
module evt_edge_det
  import evc_pkg::*;
(
  input  logic     clk,
  input  logic     rst,
  input  logic     level,
  input  evc_cfg_t cfg,
  output logic     pulse
);
  logic     prev_q;
  evc_cfg_t cfg_q;
  logic     pulse_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      prev_q  <= 1'b0;
      cfg_q   <= '0;
      pulse_q <= 1'b0;
    end else begin
      prev_q <= level;
      cfg_q  <= cfg;
      if (cfg != cfg_q) pulse_q <= 1'b0;
      else              pulse_q <= edge_hit(cfg.rise, prev_q, level);
    end
  end

  assign pulse = pulse_q;

  // R6: a pulse is never longer than one cycle.
  assert_single_pulse_R6: assert property (@(posedge clk) disable iff (rst)
    pulse_q |=> !pulse_q);
endmodule

// File: rtl/evt_counter.sv
module evt_counter #(
  parameter int W = 24
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         inc,
  input  logic         en,
  output logic [W-1:0] value
);
  logic [W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst)            cnt_q <= '0;
    else if (inc && en) cnt_q <= cnt_q + 1'b1;
  end

  assign value = cnt_q;

  // R7 / R8: one step per enabled pulse, modulo 2^W.
  assert_count_step_R7: assert property (@(posedge clk) disable iff (rst)
    (inc && en) |=> cnt_q == $past(cnt_q) + 1'b1);
  assert_count_hold_R7: assert property (@(posedge clk) disable iff (rst)
    !(inc && en) |=> $stable(cnt_q));
endmodule

// File: rtl/event_edge_counter.sv
module event_edge_counter
  import evc_pkg::*;
#(
  parameter int CNT_W       = 24,
  parameter int SYNC_STAGES = 2,
  parameter int DEB_HOLD    = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             evt_pin,
  input  logic             edge_rise,
  input  logic             deb_en,
  input  logic             cnt_en,
  output logic [CNT_W-1:0] count,
  output logic             evt_pulse
);
  logic     pin_s;
  logic     pin_f;
  logic     level;
  evc_cfg_t cfg;

  evt_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .d(evt_pin), .q(pin_s)
  );

  evt_debounce #(.HOLD(DEB_HOLD)) u_deb (
    .clk(clk), .rst(rst), .din(pin_s), .dout(pin_f)
  );

  assign level    = deb_en ? pin_f : pin_s;
  assign cfg.rise = edge_rise;
  assign cfg.deb  = deb_en;

  evt_edge_det u_edge (
    .clk(clk), .rst(rst), .level(level), .cfg(cfg), .pulse(evt_pulse)
  );

  evt_counter #(.W(CNT_W)) u_cnt (
    .clk(clk), .rst(rst), .inc(evt_pulse), .en(cnt_en), .value(count)
  );

  // R9: a settings change is followed by a quiet pulse output.
  assert_cfg_quiet_R9: assert property (@(posedge clk) disable iff (rst)
    !$stable({edge_rise, deb_en}) |=> !evt_pulse);

  // R1: reset clears the outputs.
  assert_reset_clear_R1: assert property (@(posedge clk)
    rst |=> (count == '0 && !evt_pulse));
endmodule

// File: tb/event_edge_counter_tb.sv
module event_edge_counter_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        evt_pin = 1'b0;
  logic        edge_rise = 1'b1;
  logic        deb_en = 1'b0;
  logic        cnt_en = 1'b1;
  logic [23:0] count;
  logic        evt_pulse;
  logic [3:0]  count_s;
  logic        pulse_s;

  int checks = 0;
  int errors = 0;
  int exp_cnt = 0;
  int exp_pul = 0;
  int pul_seen = 0;
  logic acc;

  always #5 clk = ~clk;

  event_edge_counter u_dut (
    .clk(clk), .rst(rst), .evt_pin(evt_pin), .edge_rise(edge_rise),
    .deb_en(deb_en), .cnt_en(cnt_en), .count(count), .evt_pulse(evt_pulse)
  );

  event_edge_counter #(.CNT_W(4)) u_small (
    .clk(clk), .rst(rst), .evt_pin(evt_pin), .edge_rise(edge_rise),
    .deb_en(deb_en), .cnt_en(cnt_en), .count(count_s), .evt_pulse(pulse_s)
  );

  always @(posedge clk) if (!rst && evt_pulse) pul_seen++;

  function automatic bit counts_edge(input bit rise, input bit new_lvl);
    return rise ? new_lvl : !new_lvl;
  endfunction

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic check_totals(input string tag);
    check({tag, " count"}, int'(count), exp_cnt & 24'hFFFFFF);
    check({tag, " pulses"}, pul_seen, exp_pul);
    check({"R8 wrap ", tag}, int'(count_s), exp_cnt % 16);
  endtask

  task automatic rand_phase(input bit rise, input bit deb, input int nruns);
    edge_rise = rise;
    deb_en    = deb;
    tick(8);
    acc = evt_pin;
    for (int i = 0; i < nruns; i++) begin
      int   len;
      logic lvl;
      lvl = !evt_pin;
      if (deb) len = (($urandom % 3) == 0) ? 1 + int'($urandom % 2) : 3 + int'($urandom % 6);
      else     len = 1 + int'($urandom % 5);
      evt_pin = lvl;
      tick(len);
      if (lvl != acc && (!deb || len >= 3)) begin
        acc = lvl;
        if (counts_edge(rise, lvl)) begin
          exp_cnt++;
          exp_pul++;
        end
      end
    end
    tick(10);
    check_totals("R10 random");
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    tick(3);
    check("R1 reset count", int'(count), 0);
    check("R1 reset pulse", int'(evt_pulse), 0);
    rst = 1'b0;
    tick(1);
    check("R1 after reset count", int'(count), 0);
    tick(5);

    // R2: latency without filter
    evt_pin = 1'b1;
    tick(2);
    check("R2 no early pulse", int'(evt_pulse), 0);
    tick(1);
    check("R2 pulse after k+2", int'(evt_pulse), 1);
    tick(1);
    check("R6 pulse one cycle", int'(evt_pulse), 0);
    check("R2 count after k+3", int'(count), 1);
    exp_cnt = 1; exp_pul = 1;
    evt_pin = 1'b0;
    tick(8);
    check("R3 falling ignored in rise mode", int'(count), 1);

    // R5: latency with filter
    deb_en = 1'b1;
    tick(6);
    evt_pin = 1'b1;
    tick(5);
    check("R5 no early pulse", int'(evt_pulse), 0);
    tick(1);
    check("R5 pulse after k+5", int'(evt_pulse), 1);
    tick(1);
    check("R5 count", int'(count), 2);
    exp_cnt = 2; exp_pul = 2;
    evt_pin = 1'b0;
    tick(8);

    // R4: glitch of 2 clocks rejected, 3 clocks accepted
    evt_pin = 1'b1; tick(2); evt_pin = 1'b0; tick(8);
    check("R4 two-clock glitch", int'(count), 2);
    evt_pin = 1'b1; tick(3); evt_pin = 1'b0; tick(8);
    exp_cnt++; exp_pul++;
    check("R4 three-clock run", int'(count), exp_cnt);

    // R3: falling mode
    edge_rise = 1'b0; deb_en = 1'b0;
    tick(6);
    evt_pin = 1'b1; tick(10);
    check("R3 rising ignored in fall mode", int'(count), exp_cnt);
    evt_pin = 1'b0; tick(10);
    exp_cnt++; exp_pul++;
    check("R3 falling counted", int'(count), exp_cnt);

    // R7: counter disabled
    cnt_en = 1'b0;
    evt_pin = 1'b1; tick(6); evt_pin = 1'b0; tick(8);
    exp_pul++;
    check("R7 pulse while disabled", pul_seen, exp_pul);
    check("R7 count held", int'(count), exp_cnt);
    cnt_en = 1'b1;
    tick(4);

    // R9: filter switched during a 2-clock excursion, fall mode
    evt_pin = 1'b1; tick(2);
    evt_pin = 1'b0; tick(1);
    deb_en = 1'b1;
    tick(10);
    check("R9 no spurious pulse", pul_seen, exp_pul);
    check("R9 no spurious count", int'(count), exp_cnt);
    deb_en = 1'b0;
    tick(6);
    check_totals("R9 settle");

    rand_phase(1'b1, 1'b0, 60);
    rand_phase(1'b0, 1'b0, 60);
    rand_phase(1'b1, 1'b1, 60);
    rand_phase(1'b0, 1'b1, 60);
    check("R8 enough events to wrap", int'(exp_cnt > 16), 1);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule